// File: doc/BRIEF.md
# Serial Converter Single-Shot Read Sequencer

This block is the host side of a three-byte exchange with an external successive-approximation converter over a clock-polarity-0, clock-phase-0 serial link. The user offers a command on a valid/ready handshake. The command carries a channel number, a result width choice, a reference-select flag and a power setting. The sequencer turns the command into a control byte whose top bit is always one. It lowers chip select and then clocks out 24 bits: the control byte followed by two zero bytes. At the same time it shifts in the 24 bits that the converter returns.

When the frame ends, the sequencer raises chip select and rebuilds the conversion value from the second and third received bytes. It then pulses `done` for one cycle. In the wide mode the value is twelve bits: all of byte two, then the high nibble of byte three, because the converter pads the value with four zero bits at the end. In the narrow mode the value is byte two alone, zero-extended. The first received byte is presented on its own port and plays no part in the value.

The serial clock comes from a half-period divider that runs on the system clock. Software picks the divider so that the link runs between 500 kHz and 2 MHz. Back-pressure is simple: `cmd_ready` is high only while no frame is in flight, and a command offered while it is low is dropped, not queued.

Top module: `conv_read_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `cmd_ready` is 1, `done` is 0 and `result` is 0.
- R2: The first eight bits sent on `spi_mosi`, MSB first, form the control byte {1, cmd_chan[2:0], cmd_mode8, cmd_single, cmd_pwr[1:0]}. Bit 7 is always 1 and bit 3 selects the 8-bit mode. The remaining 16 bits sent are zero.
- R3: Each frame has exactly 24 rising edges on `spi_sclk`. The clock is low whenever `spi_cs_n` is high, and `spi_mosi` does not change while the clock is high.
- R4: Every high and every low phase of `spi_sclk` lasts `half_div` system cycles, and a `half_div` of 0 acts as 1.
- R5: `spi_cs_n` falls at least one half-period before the first rising clock edge. It rises at least one half-period after the last falling edge.
- R6: In 12-bit mode, `result` = {byte2, byte3[7:4]}, where the bytes are counted in the order they are received.
- R7: In 8-bit mode, `result` = {4'b0, byte2}, and byte3 has no effect on it.
- R8: `rx_byte1` shows the first received byte after each frame, and its value never reaches `result`.
- R9: `cmd_ready` is high only while `spi_cs_n` is high and no frame is running. A command accepted on a cycle lowers `spi_cs_n` on the next cycle. A `cmd_valid` offered while `cmd_ready` is low is discarded and starts no frame.
- R10: `done` is a single-cycle pulse in the cycle in which `spi_cs_n` rises. `result` changes only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | Serial clock half-period in system cycles (0 treated as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_chan | input | 3 | Channel field of the control byte |
| cmd_mode8 | input | 1 | 1 selects the 8-bit result mode |
| cmd_single | input | 1 | Reference-select flag of the control byte |
| cmd_pwr | input | 2 | Power field of the control byte |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| done | output | 1 | One-cycle pulse when the result updates |
| result | output | RES_W | Assembled conversion value |
| rx_byte1 | output | 8 | First received byte of the last frame |

## Verification
The assertions check the cycle-level rules on every cycle: the clock stays low while chip select is high, data holds during the clock's high phase, ready only appears while idle, an accepted command starts a frame, and the done pulse lasts one cycle, coincides with chip select rising, and is the only time the result may change. Other behaviour is visible only across a whole frame, so only the bench scenarios show it. These are the contents of the control byte, the count of clock edges, the exact half-period for several divider values including zero, the setup and hold margins around chip select, and the bit gathering for each mode. The scenarios also show that byte one and the narrow-mode byte three are ignored, and that a command offered mid-frame is dropped.

// File: rtl/conv_read_seq_pkg.sv
package conv_read_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } seq_state_t;

  // Control byte layout: start marker, channel, width select, reference, power
  localparam int CTRL_W    = 8;
  localparam int MODE8_BIT = 3;

  function automatic logic [CTRL_W-1:0] build_ctrl(
    input logic [2:0] chan,
    input logic       mode8,
    input logic       single,
    input logic [1:0] pwr
  );
    return {1'b1, chan, mode8, single, pwr};
  endfunction

endpackage

// File: rtl/conv_seq_tick.sv
module conv_seq_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim_m1;

  assign lim_m1 = (half_div == '0) ? '0 : half_div - 1'b1;
  assign tick   = run && (cnt == lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/conv_seq_shift.sv
module conv_seq_shift #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift_out,
  input  logic               sample_in,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx_word
);

  logic [FRAME_W-1:0] tx_q;

  assign mosi = tx_q[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_word <= '0;
    end else begin
      if (load) begin
        tx_q <= load_word;
      end else if (shift_out) begin
        tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
      if (sample_in) begin
        rx_word <= {rx_word[FRAME_W-2:0], miso};
      end
    end
  end

endmodule

// File: rtl/conv_seq_assemble.sv
module conv_seq_assemble #(
  parameter int FRAME_W = 24,
  parameter int RES_W   = 12
) (
  input  logic [FRAME_W-1:0] rx_word,
  input  logic               mode8,
  output logic [RES_W-1:0]   value
);

  // Byte two starts one byte below the top of the frame
  localparam int B2_HI = FRAME_W - 9;

  logic [RES_W-1:0] wide_val;
  logic [RES_W-1:0] narrow_val;

  assign wide_val   = rx_word[B2_HI -: RES_W];
  assign narrow_val = {{(RES_W-8){1'b0}}, rx_word[B2_HI -: 8]};
  assign value      = mode8 ? narrow_val : wide_val;

endmodule

// File: rtl/conv_read_seq.sv
module conv_read_seq
  import conv_read_seq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FRAME_BYTES = 3,
  parameter int RES_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_chan,
  input  logic             cmd_mode8,
  input  logic             cmd_single,
  input  logic [1:0]       cmd_pwr,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [7:0]       rx_byte1
);

  localparam int FRAME_W = FRAME_BYTES * 8;
  localparam int EDGES   = 2 * FRAME_W;
  localparam int EDGE_W  = $clog2(EDGES + 1);

  seq_state_t        state;
  logic [EDGE_W-1:0] edge_cnt;
  logic              sclk_q;
  logic              cs_n_q;
  logic              mode8_q;
  logic              done_q;
  logic [RES_W-1:0]  result_q;
  logic [7:0]        byte1_q;

  logic               tick;
  logic               run;
  logic               load;
  logic               sample_in;
  logic               shift_out;
  logic [FRAME_W-1:0] load_word;
  logic [FRAME_W-1:0] rx_word;
  logic [RES_W-1:0]   asm_value;

  assign run       = (state != ST_IDLE);
  assign load      = (state == ST_IDLE) && cmd_valid;
  assign sample_in = (state == ST_SHIFT) && tick && !sclk_q;
  assign shift_out = (state == ST_SHIFT) && tick && sclk_q;
  assign load_word = {build_ctrl(cmd_chan, cmd_mode8, cmd_single, cmd_pwr),
                      {(FRAME_W-CTRL_W){1'b0}}};

  conv_seq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_div (half_div),
    .tick     (tick)
  );

  conv_seq_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .shift_out (shift_out),
    .sample_in (sample_in),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_word   (rx_word)
  );

  conv_seq_assemble #(.FRAME_W(FRAME_W), .RES_W(RES_W)) u_asm (
    .rx_word (rx_word),
    .mode8   (mode8_q),
    .value   (asm_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      mode8_q  <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
      byte1_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            cs_n_q   <= 1'b0;
            mode8_q  <= cmd_mode8;
            edge_cnt <= '0;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (edge_cnt == EDGE_W'(EDGES - 1)) state <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n_q   <= 1'b1;
            done_q   <= 1'b1;
            result_q <= asm_value;
            byte1_q  <= rx_word[FRAME_W-1 -: 8];
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign spi_sclk  = sclk_q;
  assign spi_cs_n  = cs_n_q;
  assign done      = done_q;
  assign result    = result_q;
  assign rx_byte1  = byte1_q;

endmodule

// File: rtl/conv_read_seq_chk.sv
module conv_read_seq_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             spi_sclk,
  input logic             spi_cs_n,
  input logic             spi_mosi,
  input logic             done,
  input logic [RES_W-1:0] result
);

  AST_CLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R3

  AST_MOSI_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R3

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_cs_n); // R9

  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !spi_cs_n); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n)); // R10

  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result)) |-> done); // R10

endmodule

bind conv_read_seq conv_read_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi),
  .done      (done),
  .result    (result)
);

// File: tb/conv_read_seq_bench.sv
module conv_read_seq_bench;

  localparam int DIV_W = 8;
  localparam int RES_W = 12;
  localparam int CLK_P = 20;

  typedef struct packed {
    logic [7:0]       ctrl;
    logic [RES_W-1:0] res;
    logic [7:0]       b1;
    logic [7:0]       half;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd2;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [2:0]       cmd_chan = '0;
  logic             cmd_mode8 = 1'b0;
  logic             cmd_single = 1'b0;
  logic [1:0]       cmd_pwr = '0;
  logic             spi_sclk, spi_cs_n, spi_mosi;
  logic             spi_miso = 1'b0;
  logic             done;
  logic [RES_W-1:0] result;
  logic [7:0]       rx_byte1;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  exp_t        exp_q[$];
  logic [23:0] slave_q[$];

  // slave-side observation
  logic [23:0] pat;
  logic [23:0] cap;
  int          rises;
  int          frames = 0;
  int          cur_half = 1;
  longint      t_cs_fall, t_first_rise, t_last_fall, t_last_edge, trail_t;
  bit          half_bad;

  always #(CLK_P/2) clk = ~clk;

  conv_read_seq #(.DIV_W(DIV_W), .FRAME_BYTES(3), .RES_W(RES_W)) u_conv_read_seq (
    .clk(clk), .rst_n(rst_n), .half_div(half_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_chan(cmd_chan),
    .cmd_mode8(cmd_mode8), .cmd_single(cmd_single), .cmd_pwr(cmd_pwr),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .done(done), .result(result), .rx_byte1(rx_byte1)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Converter model: mode-0 slave, changes MISO on falling edges
  always @(negedge spi_cs_n) begin
    frames++;
    pat = (slave_q.size() > 0) ? slave_q.pop_front() : 24'h0;
    spi_miso <= pat[23];
    rises = 0;
    cap = '0;
    half_bad = 0;
    t_cs_fall = $time;
    t_last_edge = 0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      cap = {cap[22:0], spi_mosi};
      if (rises == 0) t_first_rise = $time;
      else if ($time - t_last_edge != longint'(cur_half * CLK_P)) half_bad = 1;
      rises++;
      t_last_edge = $time;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      if ($time - t_last_edge != longint'(cur_half * CLK_P)) half_bad = 1;
      t_last_edge = $time;
      t_last_fall = $time;
      pat = {pat[22:0], 1'b0};
      spi_miso <= pat[23];
    end
  end

  always @(posedge spi_cs_n) trail_t = $time - t_last_fall;

  // Monitor: pops the scoreboard on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done && rst_n) begin
        if (exp_q.size() == 0) begin
          check_eq("R9 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check_eq("R2 control byte", {24'h0, cap[23:16]}, {24'h0, e.ctrl});
          check_eq("R2 zero fill", {8'h0, cap[15:0]}, 32'h0);
          check_eq("R3 rising edges", rises, 24);
          check_eq("R4 half period", {31'h0, half_bad}, 32'h0);
          check_eq("R5 lead time", {31'h0, (t_first_rise - t_cs_fall) >= longint'(e.half * CLK_P)}, 32'h1);
          check_eq("R5 trail time", {31'h0, trail_t >= longint'(e.half * CLK_P)}, 32'h1);
          check_eq("R6/R7 result", {20'h0, result}, {20'h0, e.res});
          check_eq("R8 byte1", {24'h0, rx_byte1}, {24'h0, e.b1});
        end
      end
    end
  end

  // Driver: queues expectations and slave data, then offers the command
  task automatic issue(input logic [7:0] div, input logic [2:0] chan, input logic mode8,
                       input logic single, input logic [1:0] pwr, input logic [11:0] val,
                       input logic [7:0] b1, input logic [7:0] b3_junk);
    exp_t e;
    logic [7:0] h;
    h = (div == 0) ? 8'd1 : div;
    e.ctrl = {1'b1, chan, mode8, single, pwr};
    e.res  = mode8 ? {4'h0, val[7:0]} : val;
    e.b1   = b1;
    e.half = h;
    exp_q.push_back(e);
    slave_q.push_back(mode8 ? {b1, val[7:0], b3_junk} : {b1, val, 4'h0});
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    half_div   = div;
    cur_half   = int'(h);
    cmd_chan   = chan;
    cmd_mode8  = mode8;
    cmd_single = single;
    cmd_pwr    = pwr;
    cmd_valid  = 1'b1;
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 cs_n", {31'h0, spi_cs_n}, 32'h1);
    check_eq("R1 sclk", {31'h0, spi_sclk}, 32'h0);
    check_eq("R1 ready", {31'h0, cmd_ready}, 32'h1);
    check_eq("R1 done", {31'h0, done}, 32'h0);
    check_eq("R1 result", {20'h0, result}, 32'h0);

    issue(8'd2, 3'd1, 1'b0, 1'b1, 2'd0, 12'hABC, 8'h00, 8'h00);  // R6
    drain();
    issue(8'd1, 3'd5, 1'b1, 1'b0, 2'd3, 12'h03E, 8'h7F, 8'hF7);  // R7 byte3 junk ignored
    drain();
    issue(8'd0, 3'd7, 1'b0, 1'b0, 2'd2, 12'hFFF, 8'hFF, 8'h00);  // R4 div 0, R8
    drain();

    // R9: command offered mid-frame is dropped
    issue(8'd3, 3'd0, 1'b0, 1'b1, 2'd1, 12'h001, 8'h81, 8'h00);
    repeat (10) @(negedge clk);
    check_eq("R9 ready low in frame", {31'h0, cmd_ready}, 32'h0);
    cmd_chan  = 3'd6;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    check_eq("R9 dropped frame count", frames, 4);
    check_eq("R9 idle after drop", {31'h0, spi_cs_n}, 32'h1);

    issue(8'd4, 3'd2, 1'b1, 1'b1, 2'd1, 12'h080, 8'h12, 8'hFF);  // R7
    drain();
    // R10: result held while idle
    repeat (20) @(negedge clk);
    check_eq("R10 result held", {20'h0, result}, 32'h080);
    check_eq("R10 done low idle", {31'h0, done}, 32'h0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule